// File: doc/BRIEF.md
# H4 Receive Packet Deframer

This block takes the byte stream from a host-controller link, framed in the H4 style, and rebuilds whole packets from it. The first byte of every frame names the packet kind. Only event packets (code 0x04) and ACL data packets (code 0x02) are handled. The block gathers the header for that kind and reads the payload length out of the header. It then sends the header bytes, followed by the payload bytes, on an output stream. Every output beat carries the packet kind and the packet length. The type byte is removed and never reaches the output.

A frame with an unknown type byte, or an ACL frame whose header and payload together would not fit in a packet buffer of `BUF_BYTES` bytes, is discarded. The block raises a one-cycle error pulse and goes back to hunting for a type byte.

Both streams use valid/ready. A beat moves when valid and ready are high in the same cycle.
- A source must hold valid and data steady until the beat is taken.
- While the type byte and the header are being collected, the input is always ready and the output is idle.
- While the held header is being sent out, the input is stalled.
- During the payload, the input passes straight through to the output without a register. So `in_ready` follows `out_ready`, and `out_valid` follows `in_valid` in the same cycle.

Top module: `h4_rx_deframer`

## Requirements
- R1: During and directly after reset, `in_ready` is 1, `out_valid` is 0 and both error pulses are 0.
- R2: The type code selects the header size: 0x04 means a 2-byte header (event) and 0x02 means a 4-byte header (ACL). While the header is being collected, `in_ready` is 1 and `out_valid` is 0.
- R3: The payload length comes from the header. For an event it is the second header byte. For ACL it is header bytes 3 (low) and 4 (high), read little-endian. `out_len` equals the header size plus the payload length, which is the frame length minus the type byte.
- R4: Any other type byte is taken in and dropped. `err_bad_type` is high for one cycle, in the cycle after that byte is accepted, and nothing is sent out.
- R5: For an ACL frame where 4 + length > `BUF_BYTES`, `err_oversize` is high for one cycle, in the cycle after the last header byte is accepted. Nothing is sent out, and the next input byte is treated as a type byte. The case 4 + length == `BUF_BYTES` is accepted.
- R6: Once a header is valid, its bytes are sent out in order with `in_ready` held at 0. The payload then passes through: `out_valid`=`in_valid`, `in_ready`=`out_ready`, `out_data`=`in_data`.
- R7: `out_last` is 1 only on the final byte of a packet. A packet with a zero-length payload ends on its final header byte.
- R8: `out_acl` is 1 for ACL packets and 0 for event packets. It stays constant, together with `out_len`, for the whole packet.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_last` and `out_len` hold their values.
- R10: After the last byte of a packet is taken, the next input byte is treated as a type byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte (header, then payload) |
| out_last | output | 1 | Final byte of the packet |
| out_len | output | clog2(BUF_BYTES+1) | Header plus payload length of the packet |
| out_acl | output | 1 | 1 for an ACL packet, 0 for an event packet |
| err_bad_type | output | 1 | One-cycle pulse: unknown type byte dropped |
| err_oversize | output | 1 | One-cycle pulse: ACL frame too long for the buffer |

## Verification
The handshake outputs and the payload data are combinational in the current state and the current inputs. So their expected values are due in the same cycle as the stimulus, and they are compared half a period after the inputs change. Header replay begins in the cycle after the last header byte is accepted. Each error pulse is due exactly one cycle after the byte that caused it, so the model moves its error expectation forward on a rising edge and compares it at the next falling edge. A behavioural model fed only with the accepted beats predicts every output pin in every cycle. The stimulus covers runs with gaps on the input and back-pressure on the output, and also runs without either.

// File: rtl/h4_pkg.sv
package h4_pkg;

  localparam logic [7:0] EVT_CODE = 8'h04;
  localparam logic [7:0] ACL_CODE = 8'h02;
  localparam int         EVT_HDR  = 2;
  localparam int         ACL_HDR  = 4;
  localparam int         HDR_MAX  = 4;

  typedef enum logic [1:0] {
    PH_TYPE,
    PH_HDR,
    PH_EMIT,
    PH_BODY
  } h4_phase_e;

  typedef struct packed {
    logic       known;
    logic       is_acl;
    logic [2:0] hdr_len;
  } h4_type_info_t;

endpackage

// File: rtl/h4_type_decode.sv
module h4_type_decode
  import h4_pkg::*;
(
  input  logic [7:0]    code,
  output h4_type_info_t info
);

  always_comb begin
    info = '0;
    case (code)
      EVT_CODE: begin
        info.known   = 1'b1;
        info.is_acl  = 1'b0;
        info.hdr_len = 3'(EVT_HDR);
      end
      ACL_CODE: begin
        info.known   = 1'b1;
        info.is_acl  = 1'b1;
        info.hdr_len = 3'(ACL_HDR);
      end
      default: info = '0;
    endcase
  end

endmodule

// File: rtl/h4_hdr_store.sv
module h4_hdr_store #(
  parameter  int NBYTES = 4,
  localparam int IW     = $clog2(NBYTES),
  localparam int FW     = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic [IW-1:0]       rd_idx,
  output logic [7:0]          rd_data,
  output logic [FW-1:0]       fill,
  output logic [NBYTES*8-1:0] flat
);

  logic [7:0] bytes_q [NBYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fill <= '0;
    else if (clr)   fill <= '0;
    else if (wr_en) fill <= fill + 1'b1;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            bytes_q[i] <= '0;
      else if (wr_en && fill == FW'(i))      bytes_q[i] <= wr_data;
    end
    assign flat[i*8 +: 8] = bytes_q[i];
  end

  assign rd_data = bytes_q[rd_idx];

endmodule

// File: rtl/h4_body_count.sv
module h4_body_count #(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          dec,
  output logic [LW-1:0] remain,
  output logic          is_zero,
  output logic          is_one
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remain <= '0;
    else if (load) remain <= load_val;
    else if (dec)  remain <= remain - 1'b1;
  end

  assign is_zero = (remain == '0);
  assign is_one  = (remain == LW'(1));

endmodule

// File: rtl/h4_rx_deframer.sv
module h4_rx_deframer
  import h4_pkg::*;
#(
  parameter  int BUF_BYTES = 1024,
  localparam int LW        = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic [LW-1:0] out_len,
  output logic          out_acl,
  output logic          err_bad_type,
  output logic          err_oversize
);

  localparam int IW = $clog2(HDR_MAX);
  localparam int FW = $clog2(HDR_MAX + 1);

  h4_phase_e     ph_q, ph_d;
  h4_type_info_t tinfo;
  logic          acl_q;
  logic [2:0]    need_q;
  logic [IW-1:0] emit_q;
  logic [LW-1:0] tot_q;
  logic          bad_q, ovf_q;

  logic [FW-1:0]        hdr_fill;
  logic [HDR_MAX*8-1:0] hdr_flat;
  logic [7:0]           hdr_rd;
  logic [LW-1:0]        remain;
  logic                 rem_zero, rem_one;

  logic        in_fire, out_fire;
  logic        type_fire, hdr_done, emit_end, body_end;
  logic [15:0] raw_len;
  logic [31:0] acl_total;
  logic        too_big;
  logic [LW-1:0] pay_len;

  h4_type_decode u_dec (
    .code (in_data),
    .info (tinfo)
  );

  h4_hdr_store #(.NBYTES(HDR_MAX)) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (type_fire),
    .wr_en   (ph_q == PH_HDR && in_fire),
    .wr_data (in_data),
    .rd_idx  (emit_q),
    .rd_data (hdr_rd),
    .fill    (hdr_fill),
    .flat    (hdr_flat)
  );

  h4_body_count #(.LW(LW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hdr_done && !too_big),
    .load_val (pay_len),
    .dec      (ph_q == PH_BODY && out_fire),
    .remain   (remain),
    .is_zero  (rem_zero),
    .is_one   (rem_one)
  );

  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign type_fire = (ph_q == PH_TYPE) && in_fire;

  // The header byte arriving now is the last one when fill reaches need-1.
  assign hdr_done  = (ph_q == PH_HDR) && in_fire && (3'(hdr_fill) == need_q - 3'd1);
  assign raw_len   = acl_q ? {in_data, hdr_flat[23:16]} : {8'h00, in_data};
  assign acl_total = 32'(ACL_HDR) + {16'h0000, raw_len};
  assign too_big   = acl_q && (acl_total > 32'(BUF_BYTES));
  assign pay_len   = raw_len[LW-1:0];

  assign emit_end  = (ph_q == PH_EMIT) && out_fire && ({1'b0, emit_q} == need_q - 3'd1);
  assign body_end  = (ph_q == PH_BODY) && out_fire && rem_one;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_TYPE: if (type_fire && tinfo.known) ph_d = PH_HDR;
      PH_HDR:  if (hdr_done)                 ph_d = too_big ? PH_TYPE : PH_EMIT;
      PH_EMIT: if (emit_end)                 ph_d = rem_zero ? PH_TYPE : PH_BODY;
      PH_BODY: if (body_end)                 ph_d = PH_TYPE;
      default:                               ph_d = PH_TYPE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_TYPE;
      acl_q  <= 1'b0;
      need_q <= 3'd0;
      emit_q <= '0;
      tot_q  <= '0;
      bad_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      bad_q <= type_fire && !tinfo.known;
      ovf_q <= hdr_done && too_big;
      if (type_fire && tinfo.known) begin
        acl_q  <= tinfo.is_acl;
        need_q <= tinfo.hdr_len;
      end
      if (hdr_done) begin
        emit_q <= '0;
        tot_q  <= LW'(need_q) + pay_len;
      end else if (ph_q == PH_EMIT && out_fire && !emit_end) begin
        emit_q <= emit_q + 1'b1;
      end
    end
  end

  always_comb begin
    in_ready  = 1'b1;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    case (ph_q)
      PH_EMIT: begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        out_data  = hdr_rd;
        out_last  = ({1'b0, emit_q} == need_q - 3'd1) && rem_zero;
      end
      PH_BODY: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = rem_one;
      end
      default: ;
    endcase
  end

  assign out_len      = tot_q;
  assign out_acl      = acl_q;
  assign err_bad_type = bad_q;
  assign err_oversize = ovf_q;

endmodule

// File: rtl/h4_rx_deframer_chk.sv
module h4_rx_deframer_chk #(
  parameter int LW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [7:0]    in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic [LW-1:0] out_len,
  input logic          out_acl,
  input logic          err_bad_type,
  input logic          err_oversize
);

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_len)); // R9

  AST_BAD_TYPE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_bad_type |-> !out_valid && in_ready); // R4

  AST_OVERSIZE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_oversize |-> !out_valid && in_ready); // R5

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_bad_type, err_oversize})); // R4

  AST_LAST_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !out_valid); // R10

  AST_LEN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> $stable(out_len) && $stable(out_acl)); // R8

endmodule

bind h4_rx_deframer h4_rx_deframer_chk #(.LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_last     (out_last),
  .out_len      (out_len),
  .out_acl      (out_acl),
  .err_bad_type (err_bad_type),
  .err_oversize (err_oversize)
);

// File: tb/sim_h4_rx_deframer.sv
module sim_h4_rx_deframer;

  localparam int BUF = 1024;
  localparam int LW  = $clog2(BUF + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_last, out_acl, err_bad_type, err_oversize;
  logic [7:0] out_data;
  logic [LW-1:0] out_len;

  always #10 clk = ~clk;

  h4_rx_deframer #(.BUF_BYTES(BUF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_len(out_len), .out_acl(out_acl), .err_bad_type(err_bad_type), .err_oversize(err_oversize)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  bit gappy = 0;
  bit run_model = 0;

  logic [7:0] src_q[$];
  bit pop_f = 0;

  // behavioural reference
  int ph = 0;            // 0 type, 1 header, 2 replay, 3 payload
  logic [7:0] hq[$];
  logic [7:0] eq[$];
  int need = 0;
  bit macl = 0;
  int remain = 0;
  int mlen = 0;
  bit e_bad = 0, e_ovf = 0;
  bit in_f = 0, out_f = 0;
  logic [7:0] s_data;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_model) begin
      bit xr, xv, xl;
      logic [7:0] xd;
      string rq;
      xr = 1'b1; xv = 1'b0; xl = 1'b0; xd = 8'h00;
      rq = (ph == 0) ? "R10" : (ph == 1) ? "R2" : "R6";
      if (ph == 2) begin
        xr = 1'b0; xv = 1'b1; xd = eq[0];
        xl = (eq.size() == 1) && (remain == 0);
      end else if (ph == 3) begin
        xr = out_ready; xv = in_valid; xd = in_data;
        xl = (remain == 1);
      end
      chk(in_ready == xr, rq, "in_ready", in_ready, xr);
      chk(out_valid == xv, rq, "out_valid", out_valid, xv);
      if (xv) begin
        chk(out_data == xd, (ph == 2 && !out_ready) ? "R9" : "R6", "out_data", out_data, xd);
        chk(out_last == xl, "R7", "out_last", out_last, xl);
        chk(out_len == LW'(mlen), "R3", "out_len", out_len, mlen);
        chk(out_acl == macl, "R8", "out_acl", out_acl, macl);
      end
      chk(err_bad_type == e_bad, "R4", "err_bad_type", err_bad_type, e_bad);
      chk(err_oversize == e_ovf, "R5", "err_oversize", err_oversize, e_ovf);
      in_f   = in_valid && xr;
      out_f  = xv && out_ready;
      s_data = in_data;
      pop_f  = in_f;
    end else begin
      in_f = 0; out_f = 0; pop_f = 0;
    end
  end

  always @(posedge clk) begin
    int p0;
    bit nb, no;
    p0 = ph; nb = 0; no = 0;
    if (!rst_n) begin
      ph = 0; hq.delete(); eq.delete(); remain = 0; mlen = 0; macl = 0;
    end else begin
      if (in_f) begin
        if (p0 == 0) begin
          if (s_data == 8'h04) begin ph = 1; need = 2; macl = 0; hq.delete(); end
          else if (s_data == 8'h02) begin ph = 1; need = 4; macl = 1; hq.delete(); end
          else nb = 1;
        end else if (p0 == 1) begin
          hq.push_back(s_data);
          if (hq.size() == need) begin
            int len;
            len = macl ? {s_data, hq[2]} : int'(s_data);
            if (macl && (4 + len > BUF)) begin
              no = 1; ph = 0;
            end else begin
              eq = hq; remain = len; mlen = need + len; ph = 2;
            end
          end
        end else if (p0 == 3) begin
          remain--;
          if (remain == 0) ph = 0;
        end
      end
      if (out_f && p0 == 2) begin
        void'(eq.pop_front());
        if (eq.size() == 0) ph = (remain != 0) ? 3 : 0;
      end
    end
    e_bad = nb; e_ovf = no;
  end

  // input driver: holds a byte until it is taken
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (pop_f) begin void'(src_q.pop_front()); pop_f = 0; end
      if (!(in_valid && !pop_f && src_q.size() > 0 && in_data == src_q[0] && in_valid)) begin
        if (src_q.size() > 0 && (!gappy || ($urandom % 4 != 0))) begin
          in_valid = 1'b1; in_data = src_q[0];
        end else begin
          in_valid = 1'b0;
        end
      end
      if (src_q.size() == 0) in_valid = 1'b0;
      out_ready = gappy ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  task automatic push_evt(input int len);
    src_q.push_back(8'h04); src_q.push_back(8'($urandom)); src_q.push_back(8'(len));
    for (int i = 0; i < len; i++) src_q.push_back(8'($urandom));
  endtask

  task automatic push_acl(input int len, input bit with_body);
    src_q.push_back(8'h02); src_q.push_back(8'($urandom)); src_q.push_back(8'($urandom));
    src_q.push_back(8'(len)); src_q.push_back(8'(len >> 8));
    if (with_body) for (int i = 0; i < len; i++) src_q.push_back(8'($urandom));
  endtask

  task automatic drain;
    while (src_q.size() != 0 || ph != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(err_bad_type == 1'b0 && err_oversize == 1'b0, "R1", "reset errors", {err_bad_type, err_oversize}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "post-reset idle", {in_ready, out_valid}, 2);
    run_model = 1;
    // directed frames, no gaps
    push_evt(0); push_evt(5); src_q.push_back(8'h01); push_acl(3, 1); push_acl(0, 1);
    src_q.push_back(8'hFF); push_acl(BUF - 4, 1); push_acl(BUF - 3, 0); push_evt(255); push_acl(2, 1);
    drain();
    // same mix with input gaps and output back-pressure
    gappy = 1;
    push_evt(1); push_acl(7, 1); src_q.push_back(8'h03); push_acl(BUF - 3, 0); push_evt(0); push_acl(0, 1);
    for (int k = 0; k < 40; k++) begin
      int sel;
      sel = $urandom % 5;
      if (sel == 0) push_evt($urandom % 20);
      else if (sel == 1) push_acl($urandom % 30, 1);
      else if (sel == 2) src_q.push_back(8'h80 | 8'($urandom));
      else if (sel == 3) push_acl(2000 + ($urandom % 100), 0);
      else push_evt($urandom % 3);
    end
    drain();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired R10 actual=%0d expected=%0d", src_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule